// File: doc/BRIEF.md
# Indexed and Indirect Operand Address Generator

This block turns the address field of an instruction into the effective operand address. It holds a small bank of index registers and has a dedicated address adder, separate from the arithmetic datapath. With each request it takes a base address, an index selector and an indirect flag. The adder works in the same cycle that the request is accepted, so indexing costs no cycle of its own. A direct request produces its result on the next clock edge.

When the indirect flag is set, the indexed sum names a storage word. The block issues one memory read to that word and takes the returned address field as the operand address. Only one level of indirection is taken. Every result comes with a one-cycle done strobe, and is split into a module number and an in-module offset. An address that lands in a module that is not fitted raises an error flag in place of a memory request.

Top module: `addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, done_o, err_o, mem_req_o and busy_o are low until a request is accepted.
- R2: A request with selector 0 and the indirect flag low yields addr_o equal to base_addr_i, with done_o high in the cycle after acceptance.
- R3: A selector from 1 to NUM_IDX adds that index register to the base address, modulo 32768, and the result appears with done_o in the cycle after acceptance.
- R4: A selector above NUM_IDX is treated as no indexing, so the base address passes unchanged.
- R5: A write to an index register (idx_we_i, idx_waddr_i, idx_wdata_i) is used by every request accepted in a later cycle.
- R6: An indirect request to a fitted module raises mem_req_o in the cycle after acceptance, with mem_addr_o equal to the indexed sum. Both hold stable until mem_ack_i is seen high.
- R7: In the cycle after mem_ack_i, done_o is high and addr_o equals mem_rdata_i sampled with the acknowledge. No second memory read follows.
- R8: module_o is addr_o bits [14:13] and offset_o is addr_o bits [12:0].
- R9: A module number of NUM_MODULES or above is unpopulated. A direct result or an indirect pointer there gives err_o together with done_o. An indexed indirect sum there gives err_o with done_o in the cycle after acceptance, and no memory request is made.
- R10: busy_o is high while a memory read is pending. req_valid_i is ignored during that time, and no done_o is produced for it.
- R11: err_o is never high without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Index register write enable |
| idx_waddr_i | input | SEL_W | Index register written (1..NUM_IDX) |
| idx_wdata_i | input | 15 | Value written to the index register |
| req_valid_i | input | 1 | Request strobe, accepted when busy_o is low |
| base_addr_i | input | 15 | Base address from the instruction |
| idx_sel_i | input | SEL_W | Index selector, 0 for none |
| indirect_i | input | 1 | Take one indirect hop |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 15 | Address of the pointer word |
| mem_ack_i | input | 1 | Read complete, data valid |
| mem_rdata_i | input | 15 | Address field of the returned word |
| busy_o | output | 1 | Indirect read pending |
| done_o | output | 1 | One-cycle strobe, result valid |
| err_o | output | 1 | Result lies in an unpopulated module |
| addr_o | output | 15 | Effective operand address |
| module_o | output | 2 | Module number of addr_o |
| offset_o | output | 13 | Offset of addr_o within the module |

## Verification
The assertions rely on a memory side that returns mem_ack_i only while mem_req_o is high, and on a requester that lowers req_valid_i after its request has been taken. The bench writes index registers only in cycles with no request, so no write and read of the same register fall in one cycle. Its memory model acknowledges after a random wait of zero to three cycles, and on some of those waits it drives req_valid_i to confirm that it is ignored. Bases, index values and pointers are drawn at random and cover all four module numbers, so with three modules fitted both error paths occur.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
  localparam int ADDR_W = 15;
  localparam int OFFS_W = 13;
  localparam int MOD_W  = ADDR_W - OFFS_W;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/idx_bank.sv
module idx_bank
  import addr_gen_pkg::*;
#(
  parameter int NUM_IDX = 15,
  parameter int SEL_W   = $clog2(NUM_IDX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  addr_t            wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output addr_t            rdata_o
);
  addr_t regs_q [1:NUM_IDX];

  for (genvar g = 1; g <= NUM_IDX; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && waddr_i == SEL_W'(g))        regs_q[g] <= wdata_i;
    end
  end

  // selector 0 or beyond the bank reads as zero: no indexing
  always_comb begin
    rdata_o = '0;
    for (int k = 1; k <= NUM_IDX; k++) begin
      if (rsel_i == SEL_W'(k)) rdata_o = regs_q[k];
    end
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder
  import addr_gen_pkg::*;
(
  input  addr_t a_i,
  input  addr_t b_i,
  output addr_t sum_o
);
  // dedicated adder, wraps at the address width
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/mod_check.sv
module mod_check
  import addr_gen_pkg::*;
#(
  parameter int NUM_MODULES = 4
) (
  input  addr_t addr_i,
  output logic  ok_o
);
  assign ok_o = int'(addr_i[ADDR_W-1:OFFS_W]) < NUM_MODULES;
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import addr_gen_pkg::*;
#(
  parameter int NUM_IDX     = 15,
  parameter int NUM_MODULES = 4,
  localparam int SEL_W      = $clog2(NUM_IDX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [SEL_W-1:0]  idx_waddr_i,
  input  logic [ADDR_W-1:0] idx_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [SEL_W-1:0]  idx_sel_i,
  input  logic              indirect_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MOD_W-1:0]  module_o,
  output logic [OFFS_W-1:0] offset_o
);
  state_e state_q;
  addr_t  idx_val, sum, mem_addr_q, addr_q;
  logic   sum_ok, ptr_ok, done_q, err_q, accept;

  idx_bank #(.NUM_IDX(NUM_IDX), .SEL_W(SEL_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (idx_we_i),
    .waddr_i (idx_waddr_i),
    .wdata_i (idx_wdata_i),
    .rsel_i  (idx_sel_i),
    .rdata_o (idx_val)
  );

  addr_adder u_add (
    .a_i   (base_addr_i),
    .b_i   (idx_val),
    .sum_o (sum)
  );

  mod_check #(.NUM_MODULES(NUM_MODULES)) u_chk_sum (
    .addr_i (sum),
    .ok_o   (sum_ok)
  );

  mod_check #(.NUM_MODULES(NUM_MODULES)) u_chk_ptr (
    .addr_i (mem_rdata_i),
    .ok_o   (ptr_ok)
  );

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mem_addr_q <= '0;
      addr_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (indirect_i && sum_ok) begin
              state_q    <= ST_WAIT;
              mem_addr_q <= sum;
            end else begin
              done_q <= 1'b1;
              err_q  <= !sum_ok;
              addr_q <= sum;
            end
          end
        end
        ST_WAIT: begin
          if (mem_ack_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= !ptr_ok;
            addr_q  <= mem_rdata_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_WAIT);
  assign busy_o     = (state_q == ST_WAIT);
  assign mem_addr_o = mem_addr_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign addr_o     = addr_q;
  assign module_o   = addr_q[ADDR_W-1:OFFS_W];
  assign offset_o   = addr_q[OFFS_W-1:0];
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk
  import addr_gen_pkg::*;
#(
  parameter int NUM_MODULES = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        indirect_i,
  input logic        mem_req_o,
  input addr_t       mem_addr_o,
  input logic        mem_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input addr_t       addr_o
);
  // R3
  direct_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && !indirect_i |=> done_o);

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R7
  single_hop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> done_o && !mem_req_o);

  // R9
  req_populated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> int'(mem_addr_o[ADDR_W-1:OFFS_W]) < NUM_MODULES);

  // R9
  good_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> int'(addr_o[ADDR_W-1:OFFS_W]) < NUM_MODULES);

  // R10
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_ack_i |=> !done_o);

  // R11
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind addr_gen addr_gen_chk #(.NUM_MODULES(NUM_MODULES)) u_addr_gen_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .indirect_i  (indirect_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .addr_o      (addr_o)
);

// File: tb/tb_addr_gen.sv
module tb_addr_gen;
  localparam int NUM_IDX     = 9;
  localparam int NUM_MODULES = 3;
  localparam int SEL_W       = $clog2(NUM_IDX + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             idx_we = 1'b0;
  logic [SEL_W-1:0] idx_waddr = '0;
  logic [14:0]      idx_wdata = '0;
  logic             req_valid = 1'b0;
  logic [14:0]      base_addr = '0;
  logic [SEL_W-1:0] idx_sel = '0;
  logic             indirect = 1'b0;
  logic             mem_req;
  logic [14:0]      mem_addr;
  logic             mem_ack = 1'b0;
  logic [14:0]      mem_rdata = '0;
  logic             busy, done, err;
  logic [14:0]      addr;
  logic [1:0]       module_n;
  logic [12:0]      offset;

  int checks = 0;
  int errors = 0;
  logic [14:0] model [16];

  always #10 clk = ~clk;

  addr_gen #(.NUM_IDX(NUM_IDX), .NUM_MODULES(NUM_MODULES)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .idx_we_i(idx_we), .idx_waddr_i(idx_waddr), .idx_wdata_i(idx_wdata),
    .req_valid_i(req_valid), .base_addr_i(base_addr), .idx_sel_i(idx_sel),
    .indirect_i(indirect), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .done_o(done), .err_o(err), .addr_o(addr), .module_o(module_n),
    .offset_o(offset)
  );

  function automatic logic [14:0] exp_sum(logic [14:0] b, logic [SEL_W-1:0] s);
    if (s != 0 && int'(s) <= NUM_IDX) return b + model[s];
    return b;
  endfunction

  function automatic bit fitted(logic [14:0] a);
    return int'(a[14:13]) < NUM_MODULES;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idx_write(logic [SEL_W-1:0] s, logic [14:0] v);
    @(negedge clk);
    idx_we = 1'b1; idx_waddr = s; idx_wdata = v;
    @(negedge clk);
    idx_we = 1'b0;
    if (s != 0 && int'(s) <= NUM_IDX) model[s] = v;
  endtask

  task automatic check_result(string req, logic [14:0] e);
    chk(req, "done", int'(done), 1);
    chk(req, "addr", int'(addr), int'(e));
    chk(req, "err", int'(err), int'(!fitted(e)));
    chk("R8", "module", int'(module_n), int'(e[14:13]));
    chk("R8", "offset", int'(offset), int'(e[12:0]));
  endtask

  task automatic direct_req(string req, logic [14:0] b, logic [SEL_W-1:0] s);
    logic [14:0] e;
    e = exp_sum(b, s);
    @(negedge clk);
    req_valid = 1'b1; indirect = 1'b0; base_addr = b; idx_sel = s;
    @(negedge clk);
    req_valid = 1'b0;
    check_result(req, e);
    chk(req, "mem_req", int'(mem_req), 0);
  endtask

  task automatic ind_req(logic [14:0] b, logic [SEL_W-1:0] s, logic [14:0] ptr,
                         int wait_n, bit poke);
    logic [14:0] e;
    e = exp_sum(b, s);
    @(negedge clk);
    req_valid = 1'b1; indirect = 1'b1; base_addr = b; idx_sel = s;
    @(negedge clk);
    req_valid = 1'b0;
    if (!fitted(e)) begin
      chk("R9", "done", int'(done), 1);
      chk("R9", "err", int'(err), 1);
      chk("R9", "mem_req", int'(mem_req), 0);
      return;
    end
    chk("R6", "mem_req", int'(mem_req), 1);
    chk("R6", "mem_addr", int'(mem_addr), int'(e));
    chk("R10", "busy", int'(busy), 1);
    for (int i = 0; i < wait_n; i++) begin
      if (poke) begin
        req_valid = 1'b1; indirect = 1'b0; base_addr = 15'($urandom); idx_sel = '0;
      end
      @(negedge clk);
      chk("R6", "mem_req held", int'(mem_req), 1);
      chk("R6", "mem_addr held", int'(mem_addr), int'(e));
      chk("R10", "no done while busy", int'(done), 0);
    end
    req_valid = 1'b0;
    mem_ack = 1'b1; mem_rdata = ptr;
    @(negedge clk);
    mem_ack = 1'b0;
    check_result("R7", ptr);
    chk("R7", "no second read", int'(mem_req), 0);
    chk("R10", "busy clear", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    // R1
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "mem_req in reset", int'(mem_req), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "err after reset", int'(err), 0);
    chk("R1", "busy after reset", int'(busy), 0);

    direct_req("R2", 15'h1234, '0);
    direct_req("R2", 15'h7fff, '0);
    idx_write(3, 15'h0100);
    direct_req("R5", 15'h0010, 3);
    idx_write(3, 15'h0200);
    direct_req("R5", 15'h0010, 3);
    idx_write(9, 15'h7ffe);
    direct_req("R3", 15'h0005, 9);   // wrap modulo 32768
    direct_req("R4", 15'h0abc, 12);  // beyond the bank
    direct_req("R9", 15'h6000, '0);  // module 3 unpopulated
    ind_req(15'h0040, 3, 15'h2345, 0, 1'b0);
    ind_req(15'h0040, '0, 15'h7001, 2, 1'b1);  // pointer in unpopulated module
    ind_req(15'h6100, '0, 15'h0001, 1, 1'b0);  // pointer word unpopulated

    for (int k = 1; k <= NUM_IDX; k++) idx_write(SEL_W'(k), 15'($urandom));
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0)
        idx_write(SEL_W'($urandom_range(0, 15)), 15'($urandom));
      else if (op < 6)
        direct_req("R3", 15'($urandom), SEL_W'($urandom_range(0, 15)));
      else
        ind_req(15'($urandom), SEL_W'($urandom_range(0, 15)), 15'($urandom),
                int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
    end

    repeat (2) @(negedge clk);
    chk("R11", "err idle", int'(err), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule